// File: doc/BRIEF.md
# Multi-Cycle Processor Control Sequencer with Trap Entry

This block is the main control state machine for a multi-cycle 32-bit processor that takes several clock cycles per instruction. It walks each instruction through fetch, decode and then a short path for its class: load, store, register-to-register arithmetic, conditional branch or jump. In every state it drives the datapath selects and write enables. The ALU, register file, memory and handler software are outside the block and are driven by its outputs.

Two faults leave the normal flow through dedicated trap states. An opcode that no instruction class recognises is caught at decode. Arithmetic overflow is caught at the end of a register-to-register operation, and the destination register is then left unwritten. Each trap state does several things in one pass. It steers the ALU to subtract 4 from the already-advanced PC, and the block captures that result as the faulting instruction's address. It records a one-bit reason code. It sends fetch to one fixed handler entry shared by both faults. The block holds the trap address and trap reason registers itself.

No data streams cross this block's edge. Every pin is a plain control or status level, and there is no valid/ready handshake or back-pressure. The state number is brought out so that the datapath and a bench can follow the sequence.

Top module: `mcyc_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) puts the sequencer in state 0 and clears `trap_pc` and `trap_cause` to zero.
- R2: State 0 (fetch) asserts `mem_rd`, `ir_we` and `pc_we`, with `pc_sel`=00, `alu_a_sel`=0, `alu_b_sel`=01 (constant 4) and `alu_op`=00 (add). The next state is always 1.
- R3: State 1 (decode) drives `alu_b_sel`=11 with add. By `opcode` it moves to state 2 for 100011 or 101011, state 6 for 000000, state 8 for 000100 and state 9 for 000010. Any other opcode moves it to state 10.
- R4: The memory path runs state 2 (`alu_a_sel`=1, `alu_b_sel`=10, add), then state 3 for 100011 or state 5 for 101011. State 3 (`mem_rd`, `addr_sel_data`) goes to 4. State 4 (`rf_we`, `wb_sel_mem`) goes to 0. State 5 (`mem_wr`, `addr_sel_data`) goes to 0.
- R5: State 6 drives `alu_a_sel`=1, `alu_b_sel`=00, `alu_op`=10 and goes to 7. With `alu_ovf` low, state 7 asserts `rf_we` and `dst_sel_rd` and goes to 0.
- R6: With `alu_ovf` high in state 7, `rf_we` stays low and the next state is 11. `alu_ovf` has no effect in any other state.
- R7: States 10 and 11 each drive `alu_op`=01 (subtract), `alu_a_sel`=0, `alu_b_sel`=01, `pc_sel`=11 (fixed handler address 0xC), and assert `pc_we`, `trap_pc_we` and `trap_cause_we`. Each always returns to state 0.
- R8: `trap_pc` loads `alu_result` at an edge where `trap_pc_we` is high and holds otherwise. After a trap it therefore equals the faulting instruction's fetch address.
- R9: `trap_cause` loads only while `trap_cause_we` is high. Bit 0 becomes 1 for an unrecognised opcode (state 10) and 0 for overflow (state 11). Bits 31..1 are zero.
- R10: State 8 drives `alu_a_sel`=1, `alu_b_sel`=00, subtract, `pc_we_cond` and `pc_sel`=01. State 9 drives `pc_we` and `pc_sel`=10. Both go to 0. `pc_load` equals `pc_we` OR (`pc_we_cond` AND `alu_zero`).
- R11: In every state, each control output not listed for that state in R2 to R10 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the held instruction |
| alu_ovf | input | 1 | ALU signed overflow flag |
| alu_zero | input | 1 | ALU zero flag |
| alu_result | input | 32 | ALU result, captured as the trap address |
| ctrl_state | output | 4 | Current state number, 0 to 11 |
| pc_we | output | 1 | Unconditional PC write |
| pc_we_cond | output | 1 | PC write when the ALU result is zero |
| pc_load | output | 1 | Combined PC load enable |
| pc_sel | output | 2 | PC source: 00 ALU, 01 branch target, 10 jump target, 11 handler 0xC |
| addr_sel_data | output | 1 | Memory address from the data address register |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_we | output | 1 | Instruction register write |
| wb_sel_mem | output | 1 | Register write data taken from memory |
| dst_sel_rd | output | 1 | Destination is the rd field |
| rf_we | output | 1 | Register file write |
| alu_a_sel | output | 1 | ALU A: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU B: 00 register B, 01 four, 10 immediate, 11 shifted immediate |
| alu_op | output | 2 | 00 add, 01 subtract, 10 function field |
| trap_pc_we | output | 1 | Trap address register write |
| trap_cause_we | output | 1 | Trap reason register write |
| trap_cause_val | output | 1 | Reason code being written |
| trap_pc | output | 32 | Trap address register |
| trap_cause | output | 32 | Trap reason register |

## Verification
The assertions assume only that `rst` is synchronous. They place no limit on `opcode`: any 6-bit value, including codes that belong to no instruction class, is legal stimulus. The bench also changes `opcode` and `alu_ovf` freely in the states that must ignore them, and holds the instruction's opcode only through decode and address calculation. `alu_result` comes from a bench ALU driven by the block's own selects. A wrong operand or operation choice in a trap state therefore appears as a wrong trap address.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

  localparam int OP_W = 6;
  localparam int ST_W = 4;

  typedef enum logic [ST_W-1:0] {
    S_FETCH    = 4'd0,
    S_DECODE   = 4'd1,
    S_MADDR    = 4'd2,
    S_MREAD    = 4'd3,
    S_LDWB     = 4'd4,
    S_MWRITE   = 4'd5,
    S_REXEC    = 4'd6,
    S_RDONE    = 4'd7,
    S_BRANCH   = 4'd8,
    S_JUMP     = 4'd9,
    S_TRAP_UND = 4'd10,
    S_TRAP_OVF = 4'd11
  } st_e;

  localparam logic [OP_W-1:0] OP_RTYPE = 6'b000000;
  localparam logic [OP_W-1:0] OP_LOAD  = 6'b100011;
  localparam logic [OP_W-1:0] OP_STORE = 6'b101011;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'b000100;
  localparam logic [OP_W-1:0] OP_JUMP  = 6'b000010;

  localparam logic [1:0] ALU_ADD  = 2'b00;
  localparam logic [1:0] ALU_SUB  = 2'b01;
  localparam logic [1:0] ALU_FUNC = 2'b10;

  localparam logic [1:0] BSEL_REG   = 2'b00;
  localparam logic [1:0] BSEL_FOUR  = 2'b01;
  localparam logic [1:0] BSEL_IMM   = 2'b10;
  localparam logic [1:0] BSEL_IMMSH = 2'b11;

  localparam logic [1:0] PCS_ALU  = 2'b00;
  localparam logic [1:0] PCS_TGT  = 2'b01;
  localparam logic [1:0] PCS_JMP  = 2'b10;
  localparam logic [1:0] PCS_TRAP = 2'b11;

  localparam logic CAUSE_UNDEF = 1'b1;
  localparam logic CAUSE_OVF   = 1'b0;

  typedef struct packed {
    logic       pc_we;
    logic       pc_we_cond;
    logic [1:0] pc_sel;
    logic       addr_sel_data;
    logic       mem_rd;
    logic       mem_wr;
    logic       ir_we;
    logic       wb_sel_mem;
    logic       dst_sel_rd;
    logic       rf_we;
    logic       alu_a_sel;
    logic [1:0] alu_b_sel;
    logic [1:0] alu_op;
    logic       trap_pc_we;
    logic       trap_cause_we;
    logic       trap_cause_val;
  } ctrl_t;

  function automatic logic op_known(input logic [OP_W-1:0] op);
    return (op == OP_RTYPE) || (op == OP_LOAD) || (op == OP_STORE) ||
           (op == OP_BEQ) || (op == OP_JUMP);
  endfunction

endpackage

// File: rtl/mcyc_next.sv
module mcyc_next
  import mcyc_pkg::*;
(
  input  st_e                 cur,
  input  logic [OP_W-1:0]     opcode,
  input  logic                ovf,
  output st_e                 nxt
);

  always_comb begin
    nxt = S_FETCH;
    case (cur)
      S_FETCH:  nxt = S_DECODE;
      S_DECODE: begin
        case (opcode)
          OP_LOAD, OP_STORE: nxt = S_MADDR;
          OP_RTYPE:          nxt = S_REXEC;
          OP_BEQ:            nxt = S_BRANCH;
          OP_JUMP:           nxt = S_JUMP;
          default:           nxt = S_TRAP_UND;
        endcase
      end
      S_MADDR:  nxt = (opcode == OP_STORE) ? S_MWRITE : S_MREAD;
      S_MREAD:  nxt = S_LDWB;
      S_REXEC:  nxt = S_RDONE;
      S_RDONE:  nxt = ovf ? S_TRAP_OVF : S_FETCH;
      default:  nxt = S_FETCH;
    endcase
  end

endmodule

// File: rtl/mcyc_outputs.sv
module mcyc_outputs
  import mcyc_pkg::*;
(
  input  st_e   cur,
  input  logic  ovf,
  output ctrl_t ctl
);

  always_comb begin
    ctl = '0;
    case (cur)
      S_FETCH: begin
        ctl.mem_rd    = 1'b1;
        ctl.ir_we     = 1'b1;
        ctl.pc_we     = 1'b1;
        ctl.pc_sel    = PCS_ALU;
        ctl.alu_b_sel = BSEL_FOUR;
        ctl.alu_op    = ALU_ADD;
      end
      S_DECODE: begin
        ctl.alu_b_sel = BSEL_IMMSH;
        ctl.alu_op    = ALU_ADD;
      end
      S_MADDR: begin
        ctl.alu_a_sel = 1'b1;
        ctl.alu_b_sel = BSEL_IMM;
        ctl.alu_op    = ALU_ADD;
      end
      S_MREAD: begin
        ctl.mem_rd        = 1'b1;
        ctl.addr_sel_data = 1'b1;
      end
      S_LDWB: begin
        ctl.rf_we      = 1'b1;
        ctl.wb_sel_mem = 1'b1;
      end
      S_MWRITE: begin
        ctl.mem_wr        = 1'b1;
        ctl.addr_sel_data = 1'b1;
      end
      S_REXEC: begin
        ctl.alu_a_sel = 1'b1;
        ctl.alu_b_sel = BSEL_REG;
        ctl.alu_op    = ALU_FUNC;
      end
      S_RDONE: begin
        ctl.dst_sel_rd = 1'b1;
        ctl.rf_we      = ~ovf;
      end
      S_BRANCH: begin
        ctl.alu_a_sel  = 1'b1;
        ctl.alu_b_sel  = BSEL_REG;
        ctl.alu_op     = ALU_SUB;
        ctl.pc_we_cond = 1'b1;
        ctl.pc_sel     = PCS_TGT;
      end
      S_JUMP: begin
        ctl.pc_we  = 1'b1;
        ctl.pc_sel = PCS_JMP;
      end
      S_TRAP_UND, S_TRAP_OVF: begin
        ctl.alu_a_sel      = 1'b0;
        ctl.alu_b_sel      = BSEL_FOUR;
        ctl.alu_op         = ALU_SUB;
        ctl.trap_pc_we     = 1'b1;
        ctl.trap_cause_we  = 1'b1;
        ctl.trap_cause_val = (cur == S_TRAP_UND) ? CAUSE_UNDEF : CAUSE_OVF;
        ctl.pc_we          = 1'b1;
        ctl.pc_sel         = PCS_TRAP;
      end
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/mcyc_trapregs.sv
module mcyc_trapregs #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pc_we,
  input  logic              cause_we,
  input  logic              cause_val,
  input  logic [DATA_W-1:0] alu_result,
  output logic [DATA_W-1:0] trap_pc,
  output logic [DATA_W-1:0] trap_cause
);

  localparam int PAD_W = DATA_W - 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_pc <= '0;
    end else if (pc_we) begin
      trap_pc <= alu_result;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_cause <= '0;
    end else if (cause_we) begin
      trap_cause <= {{PAD_W{1'b0}}, cause_val};
    end
  end

  a_r8_capture: assert property (@(posedge clk) disable iff (rst)
    pc_we |=> trap_pc == $past(alu_result));
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !pc_we |=> $stable(trap_pc));
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !cause_we |=> $stable(trap_cause));
  a_r9_code: assert property (@(posedge clk) disable iff (rst)
    cause_we |=> trap_cause[0] == $past(cause_val));

endmodule

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl
  import mcyc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   opcode,
  input  logic              alu_ovf,
  input  logic              alu_zero,
  input  logic [DATA_W-1:0] alu_result,
  output logic [ST_W-1:0]   ctrl_state,
  output logic              pc_we,
  output logic              pc_we_cond,
  output logic              pc_load,
  output logic [1:0]        pc_sel,
  output logic              addr_sel_data,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              ir_we,
  output logic              wb_sel_mem,
  output logic              dst_sel_rd,
  output logic              rf_we,
  output logic              alu_a_sel,
  output logic [1:0]        alu_b_sel,
  output logic [1:0]        alu_op,
  output logic              trap_pc_we,
  output logic              trap_cause_we,
  output logic              trap_cause_val,
  output logic [DATA_W-1:0] trap_pc,
  output logic [DATA_W-1:0] trap_cause
);

  st_e   cur;
  st_e   nxt;
  ctrl_t ctl;

  mcyc_next u_next (
    .cur    (cur),
    .opcode (opcode),
    .ovf    (alu_ovf),
    .nxt    (nxt)
  );

  mcyc_outputs u_out (
    .cur (cur),
    .ovf (alu_ovf),
    .ctl (ctl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= S_FETCH;
    end else begin
      cur <= nxt;
    end
  end

  mcyc_trapregs #(.DATA_W(DATA_W)) u_trap (
    .clk        (clk),
    .rst        (rst),
    .pc_we      (ctl.trap_pc_we),
    .cause_we   (ctl.trap_cause_we),
    .cause_val  (ctl.trap_cause_val),
    .alu_result (alu_result),
    .trap_pc    (trap_pc),
    .trap_cause (trap_cause)
  );

  assign ctrl_state     = cur;
  assign pc_we          = ctl.pc_we;
  assign pc_we_cond     = ctl.pc_we_cond;
  assign pc_load        = ctl.pc_we | (ctl.pc_we_cond & alu_zero);
  assign pc_sel         = ctl.pc_sel;
  assign addr_sel_data  = ctl.addr_sel_data;
  assign mem_rd         = ctl.mem_rd;
  assign mem_wr         = ctl.mem_wr;
  assign ir_we          = ctl.ir_we;
  assign wb_sel_mem     = ctl.wb_sel_mem;
  assign dst_sel_rd     = ctl.dst_sel_rd;
  assign rf_we          = ctl.rf_we;
  assign alu_a_sel      = ctl.alu_a_sel;
  assign alu_b_sel      = ctl.alu_b_sel;
  assign alu_op         = ctl.alu_op;
  assign trap_pc_we     = ctl.trap_pc_we;
  assign trap_cause_we  = ctl.trap_cause_we;
  assign trap_cause_val = ctl.trap_cause_val;

  a_r2_fetch_next: assert property (@(posedge clk) disable iff (rst)
    cur == S_FETCH |=> cur == S_DECODE);
  a_r3_undef_trap: assert property (@(posedge clk) disable iff (rst)
    (cur == S_DECODE && !op_known(opcode)) |=> cur == S_TRAP_UND);
  a_r6_ovf_trap: assert property (@(posedge clk) disable iff (rst)
    (cur == S_RDONE && alu_ovf) |=> cur == S_TRAP_OVF);
  a_r6_no_rf_write: assert property (@(posedge clk) disable iff (rst)
    (cur == S_RDONE && alu_ovf) |-> !rf_we);
  a_r7_return: assert property (@(posedge clk) disable iff (rst)
    (cur == S_TRAP_UND || cur == S_TRAP_OVF) |=> cur == S_FETCH);
  a_r7_redirect: assert property (@(posedge clk) disable iff (rst)
    trap_pc_we |-> (pc_we && pc_sel == PCS_TRAP && alu_op == ALU_SUB));
  a_r11_mem_wr_only: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> cur == S_MWRITE);
  a_r11_mem_excl: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

endmodule

// File: tb/tb_mcyc_ctrl.sv
`timescale 1ns/1ps
module tb_mcyc_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  opcode = '0;
  logic        alu_ovf = 1'b0;
  logic        alu_zero = 1'b0;
  logic [31:0] alu_result = '0;
  logic [3:0]  ctrl_state;
  logic        pc_we, pc_we_cond, pc_load, addr_sel_data, mem_rd, mem_wr, ir_we;
  logic        wb_sel_mem, dst_sel_rd, rf_we, alu_a_sel;
  logic        trap_pc_we, trap_cause_we, trap_cause_val;
  logic [1:0]  pc_sel, alu_b_sel, alu_op;
  logic [31:0] trap_pc, trap_cause;

  always #2 clk = ~clk;

  mcyc_ctrl dut (
    .clk(clk), .rst(rst), .opcode(opcode), .alu_ovf(alu_ovf), .alu_zero(alu_zero),
    .alu_result(alu_result), .ctrl_state(ctrl_state), .pc_we(pc_we),
    .pc_we_cond(pc_we_cond), .pc_load(pc_load), .pc_sel(pc_sel),
    .addr_sel_data(addr_sel_data), .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_we(ir_we),
    .wb_sel_mem(wb_sel_mem), .dst_sel_rd(dst_sel_rd), .rf_we(rf_we),
    .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_op(alu_op),
    .trap_pc_we(trap_pc_we), .trap_cause_we(trap_cause_we),
    .trap_cause_val(trap_cause_val), .trap_pc(trap_pc), .trap_cause(trap_cause)
  );

  int checks = 0;
  int fails  = 0;
  bit summary_done = 1'b0;

  int          exp_state = 0;
  logic [31:0] exp_tpc = '0;
  logic [31:0] exp_cause = '0;
  logic [31:0] pc = '0;
  logic [31:0] fetch_addr = '0;
  logic [5:0]  instr_op = '0;
  logic        instr_ovf = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
  endtask

  // Expected control vector:
  // {pc_we,pc_we_cond,pc_load,pc_sel,addr_sel_data,mem_rd,mem_wr,ir_we,
  //  wb_sel_mem,dst_sel_rd,rf_we,alu_a_sel,alu_b_sel,alu_op,
  //  trap_pc_we,trap_cause_we,trap_cause_val}
  function automatic logic [19:0] exp_ctrl(input int st, input logic ovf,
                                           input logic zero);
    logic pw = 0, pwc = 0, ad = 0, mr = 0, mw = 0, ir = 0, wm = 0, dr = 0;
    logic rw = 0, as = 0, tp = 0, tc = 0, tv = 0;
    logic [1:0] ps = 0, bs = 0, op = 0;
    case (st)
      0: begin mr = 1; ir = 1; pw = 1; bs = 2'b01; end
      1: begin bs = 2'b11; end
      2: begin as = 1; bs = 2'b10; end
      3: begin mr = 1; ad = 1; end
      4: begin rw = 1; wm = 1; end
      5: begin mw = 1; ad = 1; end
      6: begin as = 1; op = 2'b10; end
      7: begin dr = 1; rw = !ovf; end
      8: begin as = 1; op = 2'b01; pwc = 1; ps = 2'b01; end
      9: begin pw = 1; ps = 2'b10; end
      10, 11: begin
        op = 2'b01; bs = 2'b01; tp = 1; tc = 1; tv = (st == 10);
        pw = 1; ps = 2'b11;
      end
      default: ;
    endcase
    return {pw, pwc, pw | (pwc & zero), ps, ad, mr, mw, ir, wm, dr, rw, as,
            bs, op, tp, tc, tv};
  endfunction

  function automatic int exp_next(input int st, input logic [5:0] op, input logic ovf);
    case (st)
      0: return 1;
      1: begin
        if (op == 6'b100011 || op == 6'b101011) return 2;
        if (op == 6'b000000) return 6;
        if (op == 6'b000100) return 8;
        if (op == 6'b000010) return 9;
        return 10;
      end
      2: return (op == 6'b101011) ? 5 : 3;
      3: return 4;
      6: return 7;
      7: return ovf ? 11 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input int st, input logic ovf);
    case (st)
      0: return "R2";
      1: return "R3";
      2, 3, 4, 5: return "R4";
      6: return "R5";
      7: return ovf ? "R6" : "R5";
      8, 9: return "R10";
      default: return "R7";
    endcase
  endfunction

  task automatic step(input logic [5:0] d_op, input logic d_ovf, input bit use_dir);
    logic [31:0] a, b, rega, regb, imm, tgt, jtgt, nxt_pc;
    logic [19:0] got, want;
    int nst;
    bit was_trap;
    if (exp_state == 0) begin
      if (use_dir) begin
        instr_op = d_op; instr_ovf = d_ovf;
      end else begin
        int r = $urandom % 10;
        case (r)
          0, 6, 7: instr_op = 6'b000000;
          2: instr_op = 6'b100011;
          3: instr_op = 6'b101011;
          4: instr_op = 6'b000100;
          5: instr_op = 6'b000010;
          default: instr_op = 6'($urandom);
        endcase
        instr_ovf = ($urandom % 3 == 0);
      end
      fetch_addr = pc;
    end
    rst      = 1'b0;
    opcode   = (exp_state == 1 || exp_state == 2) ? instr_op : 6'($urandom);
    alu_ovf  = (exp_state == 7) ? instr_ovf : 1'($urandom);
    alu_zero = 1'($urandom);
    rega = $urandom; regb = $urandom; imm = $urandom; tgt = $urandom & ~32'h3;
    jtgt = $urandom & ~32'h3;
    #1;
    a = alu_a_sel ? rega : pc;
    case (alu_b_sel)
      2'b00: b = regb;
      2'b01: b = 32'd4;
      2'b10: b = imm;
      default: b = imm << 2;
    endcase
    alu_result = (alu_op == 2'b01) ? a - b : a + b;
    #0.5;
    got = {pc_we, pc_we_cond, pc_load, pc_sel, addr_sel_data, mem_rd, mem_wr, ir_we,
           wb_sel_mem, dst_sel_rd, rf_we, alu_a_sel, alu_b_sel, alu_op,
           trap_pc_we, trap_cause_we, trap_cause_val};
    want = exp_ctrl(exp_state, alu_ovf, alu_zero);
    chk(got == want, {tag_of(exp_state, alu_ovf), "/R11 controls"}, 32'(got), 32'(want));
    nst = exp_next(exp_state, instr_op, alu_ovf);
    was_trap = (exp_state >= 10);
    if (was_trap) begin
      exp_tpc   = fetch_addr;
      exp_cause = (exp_state == 10) ? 32'd1 : 32'd0;
    end
    nxt_pc = pc;
    if (pc_load) begin
      case (pc_sel)
        2'b00: nxt_pc = alu_result;
        2'b01: nxt_pc = tgt;
        2'b10: nxt_pc = jtgt;
        default: nxt_pc = 32'hC;
      endcase
    end
    @(posedge clk);
    pc = nxt_pc;
    @(negedge clk);
    chk(32'(ctrl_state) == 32'(nst), {tag_of(exp_state, alu_ovf), " next state"},
        32'(ctrl_state), 32'(nst));
    exp_state = nst;
    chk(trap_pc == exp_tpc, "R8 trap address", trap_pc, exp_tpc);
    chk(trap_cause == exp_cause, "R9 trap reason", trap_cause, exp_cause);
    if (was_trap) chk(pc == 32'hC, "R7 handler entry", pc, 32'hC);
  endtask

  task automatic run_instr(input logic [5:0] op, input logic ovf, input bit dir);
    step(op, ovf, dir);
    while (exp_state != 0) step(op, ovf, dir);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    exp_state = 0; exp_tpc = '0; exp_cause = '0; pc = '0;
    chk(ctrl_state == 4'd0, "R1 reset state", 32'(ctrl_state), 32'd0);
    chk(trap_pc == 32'd0, "R1 reset trap address", trap_pc, 32'd0);
    chk(trap_cause == 32'd0, "R1 reset trap reason", trap_cause, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!summary_done) begin
      chk(1'b0, "watchdog expired", 32'd0, 32'd1);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    @(negedge clk);
    do_reset();
    rst = 1'b0;
    pc = 32'h0000_0100;
    // directed corner cases
    run_instr(6'b100011, 1'b0, 1'b1);  // load
    run_instr(6'b101011, 1'b0, 1'b1);  // store
    run_instr(6'b000000, 1'b0, 1'b1);  // arithmetic, no overflow
    run_instr(6'b000000, 1'b1, 1'b1);  // arithmetic with overflow -> R6 trap
    run_instr(6'b000100, 1'b0, 1'b1);  // branch
    run_instr(6'b000010, 1'b0, 1'b1);  // jump
    run_instr(6'b111111, 1'b0, 1'b1);  // unrecognised -> R3 trap
    run_instr(6'b000001, 1'b1, 1'b1);  // unrecognised, overflow ignored
    run_instr(6'b000000, 1'b1, 1'b1);  // back-to-back overflow from handler
    for (int i = 0; i < 1500; i++) run_instr(6'd0, 1'b0, 1'b0);
    // reset in the middle of an instruction after a trap
    run_instr(6'b110011, 1'b0, 1'b1);
    step(6'b000000, 1'b0, 1'b1);
    step(6'b000000, 1'b0, 1'b1);
    do_reset();
    rst = 1'b0;
    run_instr(6'b000000, 1'b0, 1'b1);
    summary();
    $finish;
  end

endmodule